// File: doc/BRIEF.md
# Jack-Detect Output Enable Switcher

This block switches four analog output enables according to whether a headphone jack is plugged in. One of two general-purpose pins is picked as the detect source. Its raw level is brought into the master-clock domain, then debounced on a slow tick made by dividing the master clock by 2^TICK_LOG2 (2^21 by default). Only a level that has been seen on several slow ticks in a row is accepted.

The debounced level chooses one of two 4-bit masks: one for "detect low" and one for "detect high". The chosen mask is ANDed with the normal per-output enables. A mask can therefore only switch an output off and can never switch one on. When detection is switched off, or the chosen pin cannot serve as a detect input, the masks are bypassed and the normal enables pass through unchanged.

Every pin is a plain control or status level. No data stream crosses this block, so it has no valid/ready handshake and nothing at its edge can apply back-pressure.

Top module: `jack_output_switch`

## Requirements
- R1: After reset the slow-tick counter, the debounce history and the debounced level `jd_level` are all 0. With detection active, `out_en` then equals `norm_en & mask_lo`.
- R2: While `slow_en` is 1, a slow tick occurs once every 2^TICK_LOG2 master-clock cycles. While `slow_en` is 0, the tick counter holds its value and no tick occurs.
- R3: The selected pin passes through a two-flop synchronizer. `jd_level` takes a new value on the third consecutive slow tick that samples that value, and not earlier. A pulse shorter than two tick periods never changes `jd_level`.
- R4: While `slow_en` is 0, `jd_level` holds its value whatever the detect pins do.
- R5: With detection active, `out_en` equals `norm_en & mask_lo` when `jd_level` is 0, and `norm_en & mask_hi` when `jd_level` is 1. Bit i of every vector belongs to output i.
- R6: An output whose `norm_en` bit is 0 always has its `out_en` bit at 0.
- R7: `src_sel` = 0 selects `jd_pin_a` as the detect source. `src_sel` = 1 selects `jd_pin_b`.
- R8: `pol_inv` has no effect on detection: the raw pin level is debounced.
- R9: `jd_pin_a` is a valid detect source only when `gpio_a_fn` is 3'b000 and `three_wire` is 0. Otherwise, with `src_sel` = 0, detection is inactive: `out_en` equals `norm_en` and `jd_level` holds.
- R10: When `jd_en` is 0, detection is inactive: `out_en` equals `norm_en` and `jd_level` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jd_pin_a | input | 1 | First candidate detect pin (asynchronous) |
| jd_pin_b | input | 1 | Second candidate detect pin (asynchronous) |
| src_sel | input | 1 | Detect source select: 0 = pin A, 1 = pin B |
| jd_en | input | 1 | Jack detection enable |
| slow_en | input | 1 | Slow tick enable |
| three_wire | input | 1 | Control interface is in 3-wire mode (pin A is a chip select) |
| gpio_a_fn | input | 3 | Pin A function select; 3'b000 means input |
| pol_inv | input | 1 | Pin A polarity-invert setting; ignored for detection |
| mask_lo | input | 4 | Output mask used when the debounced level is 0 |
| mask_hi | input | 4 | Output mask used when the debounced level is 1 |
| norm_en | input | 4 | Normal per-output enables |
| out_en | output | 4 | Final output enables |
| jd_level | output | 1 | Debounced detect level |

## Verification
The assertions check several rules on every cycle. `out_en` is never set where `norm_en` is clear. The bypass holds whenever detection is inactive. The debounced level moves only on an accepted slow tick. Ticks never occur on back-to-back cycles. The bench's scenarios are what show the tick period and the exact third-tick acceptance. They also show that short pulses are rejected and that the `slow_en`, `three_wire`, function-select and polarity settings have the effect their requirements state. Two exhaustive sweeps, one per debounced level, cover every combination of normal enable and mask.

// File: rtl/jd_pkg.sv
package jd_pkg;
  // Detect source encoding on src_sel
  typedef enum logic {
    SRC_PIN_A = 1'b0,
    SRC_PIN_B = 1'b1
  } jd_src_e;

  // Pin A function-select code that makes it a plain input
  localparam logic [2:0] FN_PLAIN_INPUT = 3'b000;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/jd_slow_tick.sv
module jd_slow_tick #(
  parameter int DIV_LOG2 = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam logic [DIV_LOG2-1:0] CNT_LAST = '1;

  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == CNT_LAST);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R2
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/jd_source_sel.sv
module jd_source_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       src_sel,
  input  logic       three_wire,
  input  logic [2:0] gpio_a_fn,
  output logic       src_level,
  output logic       src_valid
);
  import jd_pkg::*;

  logic [NUM_SRC-1:0] raw_pins;
  logic [NUM_SRC-1:0] synced;

  assign raw_pins = {pin_b, pin_a};

  for (genvar p = 0; p < NUM_SRC; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[SYNC_STAGES-2:0], raw_pins[p]};
    end
    assign synced[p] = stage_q[SYNC_STAGES-1];
  end

  logic pin_a_ok;
  assign pin_a_ok = (gpio_a_fn == FN_PLAIN_INPUT) && !three_wire;

  always_comb begin
    if (jd_src_e'(src_sel) == SRC_PIN_A) begin
      src_level = synced[0];
      src_valid = pin_a_ok;
    end else begin
      src_level = synced[1];
      src_valid = 1'b1;
    end
  end

  // R9
  chip_select_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (three_wire && (src_sel == 1'b0)) |-> !src_valid);
endmodule

// File: rtl/jd_debounce.sv
module jd_debounce #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic sample,
  output logic level
);
  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_nxt;
  logic             level_q;

  assign hist_nxt = {hist_q[DEPTH-2:0], sample};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      level_q <= 1'b0;
    end else if (adv) begin
      hist_q <= hist_nxt;
      if (&hist_nxt)      level_q <= 1'b1;
      else if (~|hist_nxt) level_q <= 1'b0;
    end
  end

  assign level = level_q;

  // R4
  level_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(level_q));
  // R3
  no_rise_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sample && !level_q) |=> !level_q);
  // R3
  no_fall_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sample && level_q) |=> level_q);
endmodule

// File: rtl/jd_mask_gate.sv
module jd_mask_gate #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               level,
  input  logic [NUM_OUT-1:0] mask_lo,
  input  logic [NUM_OUT-1:0] mask_hi,
  input  logic [NUM_OUT-1:0] norm_en,
  output logic [NUM_OUT-1:0] out_en
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic keep;
    always_comb begin
      if (!active)    keep = 1'b1;
      else if (level) keep = mask_hi[i];
      else            keep = mask_lo[i];
    end
    assign out_en[i] = norm_en[i] & keep;
  end

  // R6
  only_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en & ~norm_en) == '0);
  // R10
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (out_en == norm_en));
endmodule

// File: rtl/jack_output_switch.sv
module jack_output_switch #(
  parameter int TICK_LOG2   = 21,
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int AGREE_TICKS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               jd_pin_a,
  input  logic               jd_pin_b,
  input  logic               src_sel,
  input  logic               jd_en,
  input  logic               slow_en,
  input  logic               three_wire,
  input  logic [2:0]         gpio_a_fn,
  input  logic               pol_inv,
  input  logic [NUM_OUT-1:0] mask_lo,
  input  logic [NUM_OUT-1:0] mask_hi,
  input  logic [NUM_OUT-1:0] norm_en,
  output logic [NUM_OUT-1:0] out_en,
  output logic               jd_level
);
  logic tick;
  logic src_level;
  logic src_valid;
  logic active;
  logic adv;

  jd_slow_tick #(.DIV_LOG2(TICK_LOG2)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (slow_en),
    .tick (tick)
  );

  jd_source_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_a     (jd_pin_a),
    .pin_b     (jd_pin_b),
    .src_sel   (src_sel),
    .three_wire(three_wire),
    .gpio_a_fn (gpio_a_fn),
    .src_level (src_level),
    .src_valid (src_valid)
  );

  assign active = jd_en && src_valid;
  assign adv    = tick && active;

  jd_debounce #(.DEPTH(AGREE_TICKS)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .sample(src_level),
    .level (jd_level)
  );

  jd_mask_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .level  (jd_level),
    .mask_lo(mask_lo),
    .mask_hi(mask_hi),
    .norm_en(norm_en),
    .out_en (out_en)
  );

  // R8
  pol_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pol_inv) && !$past(adv)) |-> $stable(jd_level));
  // R10
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jd_en |=> $stable(jd_level));
endmodule

// File: tb/jack_output_switch_test.sv
module jack_output_switch_test;
  localparam int TL = 3;
  localparam int TP = 1 << TL; // tick period in cycles

  logic       clk = 1'b0;
  logic       rst_n;
  logic       jd_pin_a, jd_pin_b, src_sel, jd_en, slow_en, three_wire, pol_inv;
  logic [2:0] gpio_a_fn;
  logic [3:0] mask_lo, mask_hi, norm_en, out_en;
  logic       jd_level;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  jack_output_switch #(.TICK_LOG2(TL)) uut (
    .clk(clk), .rst_n(rst_n), .jd_pin_a(jd_pin_a), .jd_pin_b(jd_pin_b),
    .src_sel(src_sel), .jd_en(jd_en), .slow_en(slow_en), .three_wire(three_wire),
    .gpio_a_fn(gpio_a_fn), .pol_inv(pol_inv), .mask_lo(mask_lo), .mask_hi(mask_hi),
    .norm_en(norm_en), .out_en(out_en), .jd_level(jd_level)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep(input bit lvl, input string tag);
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 16; m++) begin
        norm_en = 4'(n);
        mask_lo = lvl ? ~4'(m) : 4'(m);
        mask_hi = lvl ? 4'(m) : ~4'(m);
        #1;
        chk(out_en == 4'(n & m), tag, out_en, n & m);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; jd_pin_a = 0; jd_pin_b = 0; src_sel = 1; jd_en = 1; slow_en = 1;
    three_wire = 0; pol_inv = 0; gpio_a_fn = 3'b000;
    mask_lo = 4'h5; mask_hi = 4'hA; norm_en = 4'hF;
    cyc(4);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk(jd_level == 1'b0, "R1 level", jd_level, 0);
    chk(out_en == 4'h5, "R1 out_en", out_en, 5);

    // R5 R6 exhaustive at level 0
    sweep(1'b0, "R5/R6 level0");

    // R7 pin B high, steady -> level 1
    jd_pin_b = 1;
    cyc(5 * TP);
    chk(jd_level == 1'b1, "R7 pin B rise", jd_level, 1);
    sweep(1'b1, "R5/R6 level1");

    // R3 short low pulse is rejected
    jd_pin_b = 0;
    cyc(2 * TP);
    jd_pin_b = 1;
    cyc(5 * TP);
    chk(jd_level == 1'b1, "R3 glitch rejected", jd_level, 1);

    // R4 slow clock off: level holds
    slow_en = 0;
    cyc(1);
    jd_pin_b = 0;
    cyc(8 * TP);
    chk(jd_level == 1'b1, "R4 hold slow_en=0", jd_level, 1);

    // R2 R3 exact tick count: 2 ticks not enough, 3rd accepts
    slow_en = 1;
    cyc(2 * TP);
    chk(jd_level == 1'b1, "R2/R3 after two ticks", jd_level, 1);
    cyc(TP);
    chk(jd_level == 1'b0, "R2/R3 on third tick", jd_level, 0);

    // R7 pin A selected
    src_sel = 0; jd_pin_a = 1; jd_pin_b = 0;
    cyc(5 * TP);
    chk(jd_level == 1'b1, "R7 pin A rise", jd_level, 1);

    // R8 polarity invert ignored
    pol_inv = 1;
    cyc(5 * TP);
    chk(jd_level == 1'b1, "R8 pol_inv high level kept", jd_level, 1);
    jd_pin_a = 0;
    cyc(5 * TP);
    chk(jd_level == 1'b0, "R8 raw low followed", jd_level, 0);
    pol_inv = 0;

    // R9 three-wire mode blocks pin A
    three_wire = 1; mask_lo = 4'h0; mask_hi = 4'h0;
    for (int n = 0; n < 16; n++) begin
      norm_en = 4'(n); #1;
      chk(out_en == 4'(n), "R9 three_wire bypass", out_en, n);
    end
    jd_pin_a = 1;
    cyc(5 * TP);
    chk(jd_level == 1'b0, "R9 three_wire level hold", jd_level, 0);
    three_wire = 0;
    for (int f = 1; f < 8; f++) begin
      gpio_a_fn = 3'(f); norm_en = 4'hB; #1;
      chk(out_en == 4'hB, "R9 fn not input bypass", out_en, 11);
    end
    gpio_a_fn = 3'b101;
    cyc(5 * TP);
    chk(jd_level == 1'b0, "R9 fn not input level hold", jd_level, 0);
    gpio_a_fn = 3'b000;
    cyc(1);
    chk(out_en == 4'h0, "R9 fn input masks apply", out_en, 0);

    // R10 detection disabled
    jd_en = 0; src_sel = 1; jd_pin_b = 1;
    for (int n = 0; n < 16; n++) begin
      norm_en = 4'(n); #1;
      chk(out_en == 4'(n), "R10 disabled bypass", out_en, n);
    end
    cyc(5 * TP);
    chk(jd_level == 1'b0, "R10 disabled level hold", jd_level, 0);
    jd_en = 1; mask_hi = 4'h6; norm_en = 4'hF;
    cyc(5 * TP);
    chk(jd_level == 1'b1, "R10 re-enabled follows pin", jd_level, 1);
    chk(out_en == 4'h6, "R5 mask_hi applied", out_en, 6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule